// File: doc/BRIEF.md
# Serial Register Write Port

This block is a write-only serial slave that fills a small bank of eight 8-bit configuration registers from a host controller. The host lowers an active-low select line and then shifts a frame on a data line, MSB first, with a serial clock. The frame has four parts. First comes a fixed 7-bit device address. Next is a direction bit, which must mark a write. Then comes a pointer byte that picks the target register and says whether the pointer advances. One or more data bytes follow. The register contents are always visible as a flat vector. A one-cycle strobe reports each write that lands, with the register index and the data byte.

The select, clock and data lines are asynchronous to the system clock. They are resynchronized through two-flop chains. Serial clock rising edges are found in the system domain, so the serial clock must run well below the system clock. Any frame whose address or direction is wrong is discarded as a whole. If the select line is raised early, the frame ends and any partial byte is dropped.

Top module: `spi_regload`

## Requirements
- R1: While rst_ni is low, all eight registers read 0x00 and wr_stb_o is 0.
- R2: While csn_i is low, sdi_i is captured MSB first on each rising edge of sclk_i. Each high and each low phase of sclk_i lasts at least 3 clk_i cycles, and sdi_i is stable around the rising edge. The frame is sent in this order: a 7-bit address, a direction bit, a pointer byte, then data bytes.
- R3: If the 7-bit address is not 1001111 (0x4F), no register changes and no strobe occurs for the rest of the frame.
- R4: If the direction bit (the 8th bit) is 1, no register changes and no strobe occurs for that frame.
- R5: Pointer byte bit 7 is the increment flag and bits 6:0 are the register index. Each complete data byte is written to the register at the current index. Register index i (1 to 8) appears on regs_o[8*(i-1)+7 : 8*(i-1)].
- R6: When the increment flag is 0, every data byte in the frame goes to the same register index.
- R7: When the increment flag is 1, the index advances by one after each data byte, wrapping from 127 to 0.
- R8: A data byte aimed at an index outside 1 to 8 is dropped with no strobe. When the increment flag is 1, the index still advances past it.
- R9: Raising csn_i at any point ends the frame. A partly received byte is discarded, and the next frame starts from the address field.
- R10: Each landed write raises wr_stb_o for exactly one clk_i cycle. In that cycle wr_idx_o and wr_data_o carry the index and byte, and regs_o already shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csn_i | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| regs_o | output | 64 | Register bank, index 1 in the low byte |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_idx_o | output | 7 | Register index of the write |
| wr_data_o | output | 8 | Data byte of the write |

## Verification
A wrong bit counter or frame state shows up at the ports as a strobe at the wrong time or a byte landing in the wrong register. This is visible within one byte time of the fault, about five system clocks after the faulty serial edge. A wrong pointer appears once the next data byte lands, as a strobe carrying the wrong index. A stale partial byte after an abort shows as wrong bit alignment in the register value of the next frame. Random frames, with some bad addresses and read flags mixed in, are checked register by register against a bench model after every frame.

// File: rtl/spi_regload_pkg.sv
package spi_regload_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    ST_ADDR,
    ST_MAP,
    ST_DATA,
    ST_DROP
  } rx_state_e;

  typedef struct packed {
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/spi_regload_sync.sv
module spi_regload_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_regload_rx.sv
module spi_regload_rx
  import spi_regload_pkg::*;
#(
  parameter logic [IDX_W-1:0] DEV_ADDR = 7'b1001111
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    csn_s_i,
  input  logic    sclk_s_i,
  input  logic    sdi_s_i,
  output logic    req_vld_o,
  output wr_req_t req_o
);
  localparam int CNT_W = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_nxt;
  logic [IDX_W-1:0]  ptr_q;
  logic              inc_q;
  logic              sclk_q;
  logic              rise;
  logic              last_bit;
  logic              req_vld_q;
  wr_req_t           req_q;

  assign rise     = sclk_s_i & ~sclk_q;
  assign last_bit = (cnt_q == CNT_W'(DATA_W-1));
  assign sh_nxt   = {sh_q[DATA_W-2:0], sdi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_ADDR;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      inc_q     <= 1'b0;
      sclk_q    <= 1'b0;
      req_vld_q <= 1'b0;
      req_q     <= '0;
    end else begin
      sclk_q    <= sclk_s_i;
      req_vld_q <= 1'b0;
      if (csn_s_i) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
      end else if (rise) begin
        sh_q  <= sh_nxt;
        cnt_q <= cnt_q + CNT_W'(1);
        if (last_bit) begin
          case (state_q)
            ST_ADDR: state_q <= (sh_nxt[DATA_W-1:1] == DEV_ADDR && !sh_nxt[0]) ? ST_MAP : ST_DROP;
            ST_MAP: begin
              ptr_q   <= sh_nxt[IDX_W-1:0];
              inc_q   <= sh_nxt[DATA_W-1];
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              req_vld_q  <= 1'b1;
              req_q.idx  <= ptr_q;
              req_q.data <= sh_nxt;
              if (inc_q) ptr_q <= ptr_q + IDX_W'(1);
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign req_vld_o = req_vld_q;
  assign req_o     = req_q;

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s_i |=> (cnt_q == '0 && state_q == ST_ADDR)) else $error("abort not idle"); // R9
  AST_NO_REQ_OUTSIDE_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_DATA) |=> !req_vld_q) else $error("request outside data phase"); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!csn_s_i && rise && last_bit && state_q == ST_DATA && inc_q) |=> ptr_q == $past(ptr_q) + IDX_W'(1))
    else $error("pointer did not advance"); // R7
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !inc_q) |=> $stable(ptr_q)) else $error("pointer moved"); // R6
endmodule

// File: rtl/spi_regload_regfile.sv
module spi_regload_regfile
  import spi_regload_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int BASE_IDX = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_vld_i,
  input  wr_req_t                    req_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       stb_o,
  output logic [IDX_W-1:0]           stb_idx_o,
  output logic [DATA_W-1:0]          stb_data_o
);
  localparam logic [IDX_W:0] LO = (IDX_W+1)'(BASE_IDX);
  localparam logic [IDX_W:0] HI = (IDX_W+1)'(BASE_IDX + NUM_REGS);

  logic [DATA_W-1:0] reg_q [NUM_REGS];
  logic              hit;
  logic              stb_q;
  logic [IDX_W-1:0]  stb_idx_q;
  logic [DATA_W-1:0] stb_data_q;

  assign hit = req_vld_i && ({1'b0, req_i.idx} >= LO) && ({1'b0, req_i.idx} < HI);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                     reg_q[i] <= '0;
      else if (hit && req_i.idx == IDX_W'(BASE_IDX + i)) reg_q[i] <= req_i.data;
    assign regs_o[i*DATA_W +: DATA_W] = reg_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q      <= 1'b0;
      stb_idx_q  <= '0;
      stb_data_q <= '0;
    end else begin
      stb_q <= hit;
      if (hit) begin
        stb_idx_q  <= req_i.idx;
        stb_data_q <= req_i.data;
      end
    end
  end

  assign stb_o      = stb_q;
  assign stb_idx_o  = stb_idx_q;
  assign stb_data_o = stb_data_q;

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_q |-> $stable(regs_o)) else $error("register changed without strobe"); // R4
  AST_STB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_q && !$past(stb_q)) |=> !stb_q) else $error("strobe too long"); // R10
  AST_STB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> ({1'b0, stb_idx_q} >= LO && {1'b0, stb_idx_q} < HI)) else $error("strobe index out of range"); // R8
endmodule

// File: rtl/spi_regload.sv
module spi_regload
  import spi_regload_pkg::*;
#(
  parameter logic [IDX_W-1:0] DEV_ADDR    = 7'b1001111,
  parameter int               NUM_REGS    = 8,
  parameter int               BASE_IDX    = 1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       csn_i,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       wr_stb_o,
  output logic [IDX_W-1:0]           wr_idx_o,
  output logic [DATA_W-1:0]          wr_data_o
);
  logic [2:0] pins_s;
  logic       req_vld;
  wr_req_t    req;

  // bit order: {sdi, sclk, csn}; csn idles high
  spi_regload_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sdi_i, sclk_i, csn_i}),
    .q_o    (pins_s)
  );

  spi_regload_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csn_s_i   (pins_s[0]),
    .sclk_s_i  (pins_s[1]),
    .sdi_s_i   (pins_s[2]),
    .req_vld_o (req_vld),
    .req_o     (req)
  );

  spi_regload_regfile #(.NUM_REGS(NUM_REGS), .BASE_IDX(BASE_IDX)) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_vld_i  (req_vld),
    .req_i      (req),
    .regs_o     (regs_o),
    .stb_o      (wr_stb_o),
    .stb_idx_o  (wr_idx_o),
    .stb_data_o (wr_data_o)
  );
endmodule

// File: tb/spi_regload_bench.sv
`timescale 1ns/1ps
module spi_regload_bench;
  localparam int NREG = 8;
  localparam logic [6:0] DEV = 7'b1001111;

  logic clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [NREG*8-1:0] regs_o;
  logic       wr_stb;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;

  spi_regload u_spi_regload (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sclk_i(sclk), .sdi_i(sdi),
    .regs_o(regs_o), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, stb_cnt = 0;
  logic       prev_stb = 1'b0;
  logic [6:0] last_idx = '0;
  logic [7:0] last_data = '0;
  logic [7:0] exp_regs [NREG];
  logic [7:0] tx [16];
  int         exp_stb;
  logic [6:0] exp_idx;
  logic [7:0] exp_data;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_stb) begin
        stb_cnt++;
        last_idx  = wr_idx;
        last_data = wr_data;
        chk(!prev_stb, "R10 strobe one cycle", 32'(prev_stb), 0);
        if (wr_idx >= 7'd1 && wr_idx <= 7'd8)
          chk(regs_o[8*(int'(wr_idx)-1) +: 8] == wr_data, "R10 register equals strobe data",
              32'(regs_o[8*(int'(wr_idx)-1) +: 8]), 32'(wr_data));
        else
          chk(1'b0, "R8 strobe index out of range", 32'(wr_idx), 1);
      end
      prev_stb = wr_stb;
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    repeat (3) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(v[7-i]);
  endtask

  task automatic end_frame();
    @(negedge clk); sclk = 1'b0;
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NREG; i++)
      chk(regs_o[8*i +: 8] == exp_regs[i], tag, 32'(regs_o[8*i +: 8]), 32'(exp_regs[i]));
    chk(stb_cnt == exp_stb, {tag, " strobe count"}, 32'(stb_cnt), 32'(exp_stb));
    if (exp_stb > 0) begin
      chk(last_idx == exp_idx, {tag, " last index"}, 32'(last_idx), 32'(exp_idx));
      chk(last_data == exp_data, {tag, " last data"}, 32'(last_data), 32'(exp_data));
    end
  endtask

  task automatic model(input logic [6:0] a, input logic rw, input logic [7:0] mp, input int n);
    logic [6:0] ptr;
    exp_stb = 0;
    if (a == DEV && !rw) begin
      ptr = mp[6:0];
      for (int k = 0; k < n; k++) begin
        if (ptr >= 7'd1 && ptr <= 7'd8) begin
          exp_regs[int'(ptr)-1] = tx[k];
          exp_stb++;
          exp_idx  = ptr;
          exp_data = tx[k];
        end
        if (mp[7]) ptr = ptr + 7'd1;
      end
    end
  endtask

  task automatic run_frame(input logic [6:0] a, input logic rw, input logic [7:0] mp,
                           input int n, input int part, input string tag);
    model(a, rw, mp, n);
    stb_cnt = 0;
    @(negedge clk); csn = 1'b0;
    repeat (4) @(negedge clk);
    send_byte({a, rw}, 8);
    send_byte(mp, 8);
    for (int k = 0; k < n; k++) send_byte(tx[k], 8);
    if (part > 0) send_byte(8'hA5, part);
    end_frame();
    check_all(tag);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < NREG; i++)
      chk(regs_o[8*i +: 8] == 8'h00, "R1 reset register", 32'(regs_o[8*i +: 8]), 0);
    chk(wr_stb == 1'b0, "R1 reset strobe", 32'(wr_stb), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    tx[0] = 8'h3C;
    run_frame(DEV, 1'b0, 8'h03, 1, 0, "R5 single write");

    tx[0] = 8'h11; tx[1] = 8'h22; tx[2] = 8'h33;
    run_frame(DEV, 1'b0, 8'h05, 3, 0, "R6 fixed pointer");

    for (int k = 0; k < 8; k++) tx[k] = 8'(8'hA0 + k);
    run_frame(DEV, 1'b0, 8'h81, 8, 0, "R7 block write");

    tx[0] = 8'h5A;
    run_frame(DEV ^ 7'h01, 1'b0, 8'h02, 1, 0, "R3 address mismatch");
    run_frame(DEV, 1'b1, 8'h02, 1, 0, "R4 read flag");

    tx[0] = 8'hEE; tx[1] = 8'hDD;
    run_frame(DEV, 1'b0, 8'h00, 2, 0, "R8 index zero");
    tx[0] = 8'h71; tx[1] = 8'h72; tx[2] = 8'h73; tx[3] = 8'h74;
    run_frame(DEV, 1'b0, 8'h87, 4, 0, "R8 block past top");
    run_frame(DEV, 1'b0, 8'hFF, 3, 0, "R7 pointer wrap");

    tx[0] = 8'h0F;
    run_frame(DEV, 1'b0, 8'h82, 1, 5, "R9 partial byte dropped");

    // R9 abort inside the header, then a clean frame must align
    stb_cnt = 0; exp_stb = 0;
    @(negedge clk); csn = 1'b0;
    repeat (4) @(negedge clk);
    send_byte({DEV, 1'b0}, 5);
    end_frame();
    check_all("R9 header abort");
    tx[0] = 8'hC3;
    run_frame(DEV, 1'b0, 8'h04, 1, 0, "R9 frame after abort");

    for (int f = 0; f < 40; f++) begin
      logic [6:0] a;
      logic       rw;
      logic [7:0] mp;
      int         n;
      a  = ($urandom % 4 == 0) ? 7'($urandom % 128) : DEV;
      rw = ($urandom % 5 == 0);
      mp = {1'($urandom % 2), 7'($urandom % 11)};
      n  = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) tx[k] = 8'($urandom);
      run_frame(a, rw, mp, n, int'($urandom % 3) * 3, "R2 random frame");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule